// File: doc/BRIEF.md
# Instruction-Length Beat and State Sequencer

This block produces the timing strobes for a small hardwired controller. A machine instruction runs through one, two or three states. Each state is split into two beats. In the first beat a source drives the shared bus, and in the second beat a destination captures it. The sequencer keeps a state index and a beat flag. It shows them as one-hot strobes that the control-signal logic combines with the decoded instruction. A halt instruction stops the sequencer until a synchronous clear arrives.

The decoded instruction class is presented while the opcode travels from program memory into the instruction register, during the second beat of the first state. The sequencer samples the class on the edge that ends that beat, which is the same edge that loads the instruction register. It keeps its own copy of the resulting state count, so later changes on the class input have no effect until the next fetch. The `step_en` input gates every advance. Holding it high makes the sequencer run freely. Pulsing it for one cycle per key press moves the sequencer exactly one beat, which gives single-step operation.

Top module: `beat_state_seq`

## Requirements
- R1: When `rst_n` is low, and on the first edge after `sync_clr` is high, the sequencer is in state 1 (`state_stb` = 001) and beat 1 (`beat_stb` = 01, bit 0 is beat 1 and bit 1 is beat 2), with `halted` low.
- R2: On an edge where `step_en` is low and `sync_clr` is low, the strobes and `halted` keep their values. This holds even when the class input carries the halt code.
- R3: Each enabled edge toggles the beat between beat 1 and beat 2 while the sequencer is not halted.
- R4: Class code 00 (single state) on the edge that ends beat 2 of state 1 returns the sequencer to state 1, beat 1.
- R5: Class code 01 (two states) runs state 1, then state 2, then back to state 1.
- R6: Class code 10 (three states) runs state 1, state 2 and state 3, then returns to state 1, beat 1.
- R7: Class code 11 (halt) on the edge that ends beat 2 of state 1 sets `halted`. While `halted` is set, every state and beat strobe is low and `step_en` has no effect.
- R8: `sync_clr` leaves the halted condition and restarts the sequencer at state 1, beat 1.
- R9: While the sequencer is not halted, exactly one state strobe and exactly one beat strobe are high.
- R10: The class input is sampled only on the enabled edge that ends beat 2 of state 1. A value it carries at any other time has no effect.
- R11: `sync_clr` takes priority over `step_en` on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| sync_clr | input | 1 | Synchronous restart to state 1, beat 1; clears halt |
| step_en | input | 1 | Beat advance enable (tie high to free-run, pulse to single-step) |
| instr_cls | input | 2 | Decoded class: 00 single, 01 two-state, 10 three-state, 11 halt |
| state_stb | output | N_STATES (3) | One-hot state strobes, bit 0 = state 1 |
| beat_stb | output | 2 | One-hot beat strobes, bit 0 = beat 1 |
| halted | output | 1 | Set after a halt fetch, held until `sync_clr` |

## Verification
The assertions assume that `instr_cls` is a stable, settled value at each sampling edge. They also assume that `sync_clr` and `step_en` change only away from the clock edge. The bench meets both conditions by driving every input on the falling edge and reading the strobes one falling edge later. It also changes the class input deliberately during beats where it must be ignored. This lets the sampling window of R10 be observed at the strobes instead of being assumed.

// File: rtl/bss_pkg.sv
package bss_pkg;

  typedef enum logic [1:0] {
    CLS_SINGLE   = 2'b00,
    CLS_DIRECT   = 2'b01,
    CLS_INDIRECT = 2'b10,
    CLS_HALT     = 2'b11
  } instr_cls_e;

  typedef enum logic {
    BEAT_T1 = 1'b0,
    BEAT_T2 = 1'b1
  } beat_e;

  // Index of the last state used by a class (state 1 has index 0).
  function automatic int unsigned cls_last_idx(instr_cls_e c);
    case (c)
      CLS_DIRECT:   return 1;
      CLS_INDIRECT: return 2;
      default:      return 0;
    endcase
  endfunction

endpackage

// File: rtl/seq_beat.sv
module seq_beat
  import bss_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  adv,
  output beat_e beat
);

  beat_e beat_q, beat_d;

  always_comb begin
    beat_d = beat_q;
    if (clr) begin
      beat_d = BEAT_T1;
    end else if (adv) begin
      beat_d = (beat_q == BEAT_T1) ? BEAT_T2 : BEAT_T1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= BEAT_T1;
    end else begin
      beat_q <= beat_d;
    end
  end

  assign beat = beat_q;

endmodule

// File: rtl/seq_state.sv
module seq_state
  import bss_pkg::*;
#(
  parameter int unsigned N_STATES = 3,
  localparam int unsigned IDX_W = (N_STATES > 1) ? $clog2(N_STATES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  beat_e            beat,
  input  instr_cls_e       cls_in,
  output logic [IDX_W-1:0] idx,
  output logic             halt_fetch
);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] last_q, last_d;
  logic [IDX_W-1:0] fetched_last;
  logic             state_end;
  logic             in_fetch;

  assign state_end    = adv && (beat == BEAT_T2);
  assign in_fetch     = (idx_q == '0);
  assign fetched_last = IDX_W'(cls_last_idx(cls_in));
  assign halt_fetch   = state_end && in_fetch && (cls_in == CLS_HALT) && !clr;

  always_comb begin
    idx_d  = idx_q;
    last_d = last_q;
    if (clr) begin
      idx_d  = '0;
      last_d = '0;
    end else if (state_end) begin
      if (in_fetch) begin
        last_d = fetched_last;
        idx_d  = (fetched_last != '0) ? IDX_W'(1) : '0;
      end else begin
        idx_d  = (idx_q == last_q) ? '0 : idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      last_q <= '0;
    end else begin
      idx_q  <= idx_d;
      last_q <= last_d;
    end
  end

  assign idx = idx_q;

endmodule

// File: rtl/seq_halt.sv
module seq_halt (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set,
  output logic halted
);

  logic halt_q, halt_d;

  always_comb begin
    halt_d = halt_q;
    if (clr) begin
      halt_d = 1'b0;
    end else if (set) begin
      halt_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
    end else begin
      halt_q <= halt_d;
    end
  end

  assign halted = halt_q;

endmodule

// File: rtl/beat_state_seq.sv
module beat_state_seq
  import bss_pkg::*;
#(
  parameter int unsigned N_STATES = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sync_clr,
  input  logic                step_en,
  input  logic [1:0]          instr_cls,
  output logic [N_STATES-1:0] state_stb,
  output logic [1:0]          beat_stb,
  output logic                halted
);

  localparam int unsigned IDX_W = (N_STATES > 1) ? $clog2(N_STATES) : 1;

  logic             adv;
  logic             halt_set;
  logic             halt_q;
  beat_e            beat;
  logic [IDX_W-1:0] idx;
  instr_cls_e       cls;

  assign cls = instr_cls_e'(instr_cls);
  assign adv = step_en && !halt_q;

  seq_beat u_beat (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (sync_clr),
    .adv   (adv),
    .beat  (beat)
  );

  seq_state #(.N_STATES(N_STATES)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (sync_clr),
    .adv        (adv),
    .beat       (beat),
    .cls_in     (cls),
    .idx        (idx),
    .halt_fetch (halt_set)
  );

  seq_halt u_halt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (sync_clr),
    .set    (halt_set),
    .halted (halt_q)
  );

  for (genvar g = 0; g < N_STATES; g++) begin : g_state_stb
    assign state_stb[g] = !halt_q && (idx == IDX_W'(g));
  end

  assign beat_stb[0] = !halt_q && (beat == BEAT_T1);
  assign beat_stb[1] = !halt_q && (beat == BEAT_T2);
  assign halted      = halt_q;

endmodule

// File: rtl/bss_checker.sv
module bss_checker #(
  parameter int unsigned N_STATES = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sync_clr,
  input logic                step_en,
  input logic [1:0]          instr_cls,
  input logic [N_STATES-1:0] state_stb,
  input logic [1:0]          beat_stb,
  input logic                halted
);

  logic fetch_t2;
  logic live;
  assign fetch_t2 = state_stb[0] && beat_stb[1];
  assign live     = step_en && !sync_clr;

  p_clear_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> (state_stb == N_STATES'(1)) && (beat_stb == 2'b01) && !halted);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !sync_clr) |=> $stable(state_stb) && $stable(beat_stb) && $stable(halted));

  p_beat_alt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !halted && beat_stb[0]) |=> beat_stb[1]);

  p_single_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && fetch_t2 && instr_cls == 2'b00) |=> state_stb[0] && beat_stb[0]);

  p_direct_go_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && fetch_t2 && instr_cls == 2'b01) |=> state_stb[1] && beat_stb[0]);

  p_third_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && state_stb[2] && beat_stb[1]) |=> state_stb[0] && beat_stb[0]);

  p_halt_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (live && fetch_t2 && instr_cls == 2'b11) |=> halted && (state_stb == '0) && (beat_stb == 2'b00));

  p_halt_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !sync_clr) |=> halted);

  p_halt_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (state_stb == '0) && (beat_stb == 2'b00));

  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |-> ($countones(state_stb) == 1) && ($countones(beat_stb) == 1));

endmodule

bind beat_state_seq bss_checker #(.N_STATES(N_STATES)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .sync_clr  (sync_clr),
  .step_en   (step_en),
  .instr_cls (instr_cls),
  .state_stb (state_stb),
  .beat_stb  (beat_stb),
  .halted    (halted)
);

// File: tb/beat_state_seq_tb_top.sv
module beat_state_seq_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       sync_clr;
  logic       step_en;
  logic [1:0] instr_cls;
  logic [2:0] state_stb;
  logic [1:0] beat_stb;
  logic       halted;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  beat_state_seq #(.N_STATES(3)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_clr  (sync_clr),
    .step_en   (step_en),
    .instr_cls (instr_cls),
    .state_stb (state_stb),
    .beat_stb  (beat_stb),
    .halted    (halted)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Packed view {state_stb, beat_stb, halted}; s is 1..3, b is 1..2.
  function automatic logic [5:0] expv(int s, int b, bit h);
    if (h) return 6'b000001;
    return {3'(1 << (s - 1)), (b == 1) ? 2'b01 : 2'b10, 1'b0};
  endfunction

  task automatic check(string req, logic [5:0] exp);
    logic [5:0] act;
    act = {state_stb, beat_stb, halted};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_onehot(string req);
    n_chk++;
    if (!halted && ($countones(state_stb) != 1 || $countones(beat_stb) != 1)) begin
      n_bad++;
      $display("FAIL %s: actual state %b beat %b expected one-hot", req, state_stb, beat_stb);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
  task automatic tick(bit st, logic [1:0] c);
    instr_cls = c;
    step_en   = st;
    @(negedge clk);
    step_en   = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 after reset", expv(1, 1, 0));
  endtask

  task automatic t_nop();
    tick(1, 2'b00); check("R3 beat 2", expv(1, 2, 0));
    tick(1, 2'b00); check("R4 single back to S1T1", expv(1, 1, 0));
    tick(1, 2'b00); check("R3 beat 2 again", expv(1, 2, 0));
    tick(1, 2'b00); check("R4 second single", expv(1, 1, 0));
  endtask

  task automatic t_direct();
    tick(1, 2'b01); check("R5 S1T2", expv(1, 2, 0));
    tick(1, 2'b01); check("R5 S2T1", expv(2, 1, 0));
    check_onehot("R9 in S2");
    tick(1, 2'b01); check("R5 S2T2", expv(2, 2, 0));
    tick(1, 2'b01); check("R5 back to S1T1", expv(1, 1, 0));
  endtask

  task automatic t_indirect();
    tick(1, 2'b11); check("R10 halt code ignored in T1", expv(1, 2, 0));
    tick(1, 2'b10); check("R6 S2T1", expv(2, 1, 0));
    tick(1, 2'b00); check("R10 class change ignored S2T2", expv(2, 2, 0));
    tick(1, 2'b11); check("R6 S3T1", expv(3, 1, 0));
    check_onehot("R9 in S3");
    tick(1, 2'b00); check("R6 S3T2", expv(3, 2, 0));
    tick(1, 2'b00); check("R6 back to S1T1", expv(1, 1, 0));
  endtask

  task automatic t_no_step();
    tick(1, 2'b00); check("R3 to S1T2", expv(1, 2, 0));
    tick(0, 2'b11); check("R2 hold with halt code", expv(1, 2, 0));
    tick(0, 2'b10); check("R2 hold again", expv(1, 2, 0));
  endtask

  task automatic t_halt();
    tick(1, 2'b11); check("R7 halt entered", expv(1, 1, 1));
    tick(1, 2'b00); check("R7 halt sticky", expv(1, 1, 1));
    tick(1, 2'b10); check("R7 steps ignored", expv(1, 1, 1));
  endtask

  task automatic t_clear();
    sync_clr = 1'b1;
    tick(1, 2'b11);
    sync_clr = 1'b0;
    check("R8 clear leaves halt", expv(1, 1, 0));
    tick(1, 2'b10); tick(1, 2'b10); tick(1, 2'b10);
    check("R6 mid-run S2T2", expv(2, 2, 0));
    sync_clr = 1'b1;
    tick(1, 2'b10);
    sync_clr = 1'b0;
    check("R11 clear beats step", expv(1, 1, 0));
    check("R1 restart point", expv(1, 1, 0));
  endtask

  initial begin
    rst_n     = 1'b0;
    sync_clr  = 1'b0;
    step_en   = 1'b0;
    instr_cls = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nop();
    t_direct();
    t_indirect();
    t_no_step();
    t_halt();
    t_clear();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule